// File: doc/BRIEF.md
# Quadrature Encoder Position and Speed Unit

This block follows a rotary encoder through its two quadrature phase signals and its once-per-turn index pulse. An edge counter gives the position within one revolution, and a revolution counter is stepped by the index. The two counters are joined into one absolute position word. The phase inputs are already synchronized to the block clock. The block counts every phase edge (x4) and reports the decoded direction as a status bit.

For speed, a programmable time base runs next to the decoder. Its counter restarts each time it reaches the period value, and its output toggles at every restart. When decoding and speed measurement are both enabled, that output is fed back as a trigger. On each rising edge of the trigger the edge count is copied into a speed register, and the edge counter restarts in the same cycle. The speed register therefore holds the number of edges seen in one full time-base cycle. Nothing moves until software writes a start command that turns the counter clock on and issues a software trigger in the same write.

Top module: `qenc_speed_unit`

## Requirements
- R1: Phases are read as the pair AB. The forward order is 00, 10, 11, 01, back to 00. Every single-phase change along that order adds 1 to the edge count, and every change against it subtracts 1. The count wraps modulo 2^16.
- R2: A sample in which both phases change at once is ignored. It leaves the edge count and the direction bit as they were.
- R3: The `direction` output is 1 after a forward step and 0 after a reverse step. It keeps its value while there are no steps, and it is 1 after reset.
- R4: On a rising edge of `index_in`, the revolution count moves by +1 if `direction` is 1 and by -1 if it is 0. It wraps modulo 2^16.
- R5: An index rising edge clears the edge counter. A step in the same cycle is then the new count (+1, -1 or 0).
- R6: `position` holds the revolution count in bits 31:16 and the edge count in bits 15:0.
- R7: While running, the time-base counter goes back to 0 in the cycle after it reaches `cfg_period` (or a higher value), and `timebase_out` toggles at that same edge. The output therefore toggles every `cfg_period`+1 cycles.
- R8: The trigger is `timebase_out` AND `cfg_decode_en` AND `cfg_speed_en`. One cycle after the trigger rises, `speed_value` takes the edge count and the edge counter restarts, keeping a step from that same cycle.
- R9: Without a trigger rise, `speed_value` holds its value. With `cfg_speed_en` at 0, only the index clears the edge counter.
- R10: Counters and time base stay frozen until a write with `cmd_write`, `cmd_clock_on` and `cmd_soft_trig` all 1. That write clears the edge count, the revolution count, the time base and `timebase_out`, and keeps `speed_value`.
- R11: After reset, `position`, `revolutions`, `speed_value` and `timebase_out` are 0 and `direction` is 1.
- R12: While `cfg_decode_en` is 0, steps and index edges change neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Quadrature phase A, synchronized |
| phase_b | input | 1 | Quadrature phase B, synchronized |
| index_in | input | 1 | Once-per-turn index, synchronized |
| cfg_decode_en | input | 1 | Enables quadrature counting |
| cfg_speed_en | input | 1 | Enables time-base capture |
| cfg_period | input | PER_W | Time-base terminal count |
| cmd_write | input | 1 | Command write strobe |
| cmd_clock_on | input | 1 | Command bit: enable counter clock |
| cmd_soft_trig | input | 1 | Command bit: software trigger |
| position | output | 2*CNT_W | Revolution count above edge count |
| revolutions | output | CNT_W | Revolution count |
| speed_value | output | CNT_W | Edges per time-base cycle |
| direction | output | 1 | 1 forward, 0 reverse |
| timebase_out | output | 1 | Time-base toggle output |

## Verification
The bench aims at same-cycle collisions: a step landing on a capture or an index clear, which a wrong design would lose or double count. It also drives illegal double-phase changes, which a naive decoder would count or would use to flip the direction. Index edges in reverse must take the revolution count down through zero to 0xFFFF. The bench writes a clock-enable command without the trigger and moves the phases while the block is stopped, so a design that starts too early is caught. It changes the period at run time and turns speed measurement off mid-run, where a design that keeps capturing or stops holding `speed_value` shows a wrong speed.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Classification of one phase sample against the previous one
    typedef enum logic [1:0] {
        STEP_IDLE    = 2'd0,
        STEP_UP      = 2'd1,
        STEP_DOWN    = 2'd2,
        STEP_ILLEGAL = 2'd3
    } step_e;

    // One command write
    typedef struct packed {
        logic write;
        logic clock_on;
        logic soft_trig;
    } qenc_cmd_t;

    // prev and cur are {A,B}; forward order is 00,10,11,01
    function automatic step_e decode_step(input logic [1:0] prev, input logic [1:0] cur);
        logic [1:0] diff;
        diff = prev ^ cur;
        if (diff == 2'b00)
            return STEP_IDLE;
        else if (diff == 2'b11)
            return STEP_ILLEGAL;
        else if ((cur[1] ^ prev[0]) == 1'b1)
            return STEP_UP;
        else
            return STEP_DOWN;
    endfunction

    function automatic logic is_start(input qenc_cmd_t c);
        return c.write & c.clock_on & c.soft_trig;
    endfunction

    function automatic logic is_move(input step_e s);
        return (s == STEP_UP) || (s == STEP_DOWN);
    endfunction

endpackage

// File: rtl/qenc_phase_decoder.sv
module qenc_phase_decoder
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  phase_a,
    input  logic  phase_b,
    input  logic  index_in,
    input  logic  count_en,
    output step_e step,
    output logic  index_rise,
    output logic  dir_fwd
);

    logic [1:0] ab_q;
    logic       idx_q;

    // Previous samples track the inputs at all times so that enabling
    // the counters never produces a spurious step.
    always_ff @(posedge clk) begin
        if (rst) begin
            ab_q    <= {phase_a, phase_b};
            idx_q   <= index_in;
            dir_fwd <= 1'b1;
        end else begin
            ab_q  <= {phase_a, phase_b};
            idx_q <= index_in;
            if (count_en && is_move(step))
                dir_fwd <= (step == STEP_UP);
        end
    end

    always_comb begin
        step       = decode_step(ab_q, {phase_a, phase_b});
        index_rise = index_in & ~idx_q;
    end

endmodule

// File: rtl/qenc_timebase.sv
module qenc_timebase #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             tb_out,
    output logic [PER_W-1:0] tb_count
);

    logic at_end;

    always_comb at_end = (tb_count >= period);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tb_count <= '0;
            tb_out   <= 1'b0;
        end else if (run) begin
            if (at_end) begin
                tb_count <= '0;
                tb_out   <= ~tb_out;
            end else begin
                tb_count <= tb_count + PER_W'(1);
            end
        end
    end

endmodule

// File: rtl/qenc_counters.sv
module qenc_counters
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             restart,
    input  step_e            step,
    input  logic             index_rise,
    input  logic             dir_fwd,
    input  logic             capture,
    output logic [CNT_W-1:0] edge_cnt,
    output logic [CNT_W-1:0] rev_cnt,
    output logic [CNT_W-1:0] speed
);

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] MINUS = {CNT_W{1'b1}};

    logic [CNT_W-1:0] delta;
    logic             clr_edge;

    always_comb begin
        case (step)
            STEP_UP:   delta = ONE;
            STEP_DOWN: delta = MINUS;
            default:   delta = '0;
        endcase
        clr_edge = capture | index_rise;
    end

    // Edge counter: a clear keeps the step of the same cycle
    always_ff @(posedge clk) begin
        if (rst || restart)
            edge_cnt <= '0;
        else if (count_en)
            edge_cnt <= clr_edge ? delta : edge_cnt + delta;
    end

    // Revolution counter, stepped by the index in the decoded direction
    always_ff @(posedge clk) begin
        if (rst || restart)
            rev_cnt <= '0;
        else if (count_en && index_rise)
            rev_cnt <= rev_cnt + (dir_fwd ? ONE : MINUS);
    end

    // Speed capture register, untouched by a restart
    always_ff @(posedge clk) begin
        if (rst)
            speed <= '0;
        else if (capture)
            speed <= edge_cnt;
    end

endmodule

// File: rtl/qenc_speed_unit.sv
module qenc_speed_unit
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               phase_a,
    input  logic               phase_b,
    input  logic               index_in,
    input  logic               cfg_decode_en,
    input  logic               cfg_speed_en,
    input  logic [PER_W-1:0]   cfg_period,
    input  logic               cmd_write,
    input  logic               cmd_clock_on,
    input  logic               cmd_soft_trig,
    output logic [2*CNT_W-1:0] position,
    output logic [CNT_W-1:0]   revolutions,
    output logic [CNT_W-1:0]   speed_value,
    output logic               direction,
    output logic               timebase_out
);

    qenc_cmd_t        cmd;
    logic             restart;
    logic             running;
    logic             count_en;
    step_e            step_kind;
    logic             idx_rise;
    logic             trig;
    logic             trig_q;
    logic             capture;
    logic [CNT_W-1:0] edge_cnt;
    logic [PER_W-1:0] tb_count;

    always_comb begin
        cmd      = '{write: cmd_write, clock_on: cmd_clock_on, soft_trig: cmd_soft_trig};
        restart  = is_start(cmd);
        count_en = running & cfg_decode_en;
    end

    always_ff @(posedge clk) begin
        if (rst)
            running <= 1'b0;
        else if (restart)
            running <= 1'b1;
    end

    qenc_phase_decoder u_dec (
        .clk        (clk),
        .rst        (rst),
        .phase_a    (phase_a),
        .phase_b    (phase_b),
        .index_in   (index_in),
        .count_en   (count_en),
        .step       (step_kind),
        .index_rise (idx_rise),
        .dir_fwd    (direction)
    );

    qenc_timebase #(.PER_W(PER_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .restart  (restart),
        .period   (cfg_period),
        .tb_out   (timebase_out),
        .tb_count (tb_count)
    );

    // Internal feedback of the time base as capture trigger
    always_comb trig = timebase_out & cfg_decode_en & cfg_speed_en;

    always_ff @(posedge clk) begin
        if (rst)
            trig_q <= 1'b0;
        else
            trig_q <= trig;
    end

    always_comb capture = trig & ~trig_q & running;

    qenc_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .count_en   (count_en),
        .restart    (restart),
        .step       (step_kind),
        .index_rise (idx_rise),
        .dir_fwd    (direction),
        .capture    (capture),
        .edge_cnt   (edge_cnt),
        .rev_cnt    (revolutions),
        .speed      (speed_value)
    );

    always_comb position = {revolutions, edge_cnt};

endmodule

// File: rtl/qenc_checker.sv
module qenc_checker
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 16
) (
    input logic             clk,
    input logic             rst,
    input step_e            step_kind,
    input logic             idx_rise,
    input logic             capture,
    input logic             restart,
    input logic             running,
    input logic             count_en,
    input logic [CNT_W-1:0] edge_cnt,
    input logic [CNT_W-1:0] speed_value,
    input logic             direction,
    input logic             timebase_out,
    input logic [PER_W-1:0] tb_count,
    input logic [PER_W-1:0] cfg_period
);

    AST_ILLEGAL_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (step_kind == STEP_ILLEGAL && !capture && !idx_rise && !restart) |=> $stable(edge_cnt)); // R2

    AST_ILLEGAL_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
        (step_kind == STEP_ILLEGAL) |=> $stable(direction)); // R2

    AST_INDEX_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (count_en && idx_rise && step_kind == STEP_IDLE && !restart) |=> (edge_cnt == '0)); // R5

    AST_TB_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (running && !restart && tb_count >= cfg_period) |=> (timebase_out != $past(timebase_out))); // R7

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
        capture |=> (speed_value == $past(edge_cnt))); // R8

    AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (capture && step_kind == STEP_IDLE && !restart) |=> (edge_cnt == '0)); // R8

    AST_SPEED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(speed_value)); // R9

    AST_FROZEN_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
        (!running && !restart) |=> $stable(edge_cnt)); // R10

endmodule

bind qenc_speed_unit qenc_checker #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .step_kind    (step_kind),
    .idx_rise     (idx_rise),
    .capture      (capture),
    .restart      (restart),
    .running      (running),
    .count_en     (count_en),
    .edge_cnt     (edge_cnt),
    .speed_value  (speed_value),
    .direction    (direction),
    .timebase_out (timebase_out),
    .tb_count     (tb_count),
    .cfg_period   (cfg_period)
);

// File: tb/tb_qenc_speed_unit.sv
module tb_qenc_speed_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        pa, pb, idx;
    logic        qen, sen;
    logic [15:0] per;
    logic        wr, ce, st;
    logic [31:0] pos;
    logic [15:0] rev, spd;
    logic        dir, tbo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int g      = 0;

    // reference state
    logic        m_pa, m_pb, m_pi, m_dir, m_tbo, m_tq, m_run;
    logic [15:0] m_edge, m_rev, m_spd, m_tbc;

    always #10 clk = ~clk;

    qenc_speed_unit dut (
        .clk(clk), .rst(rst), .phase_a(pa), .phase_b(pb), .index_in(idx),
        .cfg_decode_en(qen), .cfg_speed_en(sen), .cfg_period(per),
        .cmd_write(wr), .cmd_clock_on(ce), .cmd_soft_trig(st),
        .position(pos), .revolutions(rev), .speed_value(spd),
        .direction(dir), .timebase_out(tbo)
    );

    // R1 encoding: AB order 00,10,11,01
    function automatic logic [1:0] gray_ab(input int k);
        case (k & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic logic fwd_of(input logic a_new, input logic b_old);
        return a_new ^ b_old;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_next();
        logic start, valid, up, cen, irise, trig, cap;
        logic [15:0] delta;
        if (rst) begin
            m_pa = pa; m_pb = pb; m_pi = idx; m_dir = 1'b1;
            m_edge = '0; m_rev = '0; m_spd = '0; m_tbc = '0;
            m_tbo = 1'b0; m_tq = 1'b0; m_run = 1'b0;
        end else begin
            start = wr & ce & st;
            valid = (pa != m_pa) ^ (pb != m_pb);
            up    = valid && fwd_of(pa, m_pb);
            cen   = m_run & qen;
            irise = idx & ~m_pi;
            trig  = m_tbo & qen & sen;
            cap   = trig & ~m_tq & m_run;
            delta = !valid ? 16'h0000 : (up ? 16'h0001 : 16'hFFFF);
            if (cap) m_spd = m_edge;
            if (start) begin
                m_edge = '0; m_rev = '0;
            end else if (cen) begin
                if (irise) m_rev = m_rev + (m_dir ? 16'h0001 : 16'hFFFF);
                m_edge = (cap || irise) ? delta : m_edge + delta;
            end
            if (cen && valid) m_dir = up;
            if (start) begin
                m_tbc = '0; m_tbo = 1'b0;
            end else if (m_run) begin
                if (m_tbc >= per) begin m_tbc = '0; m_tbo = ~m_tbo; end
                else m_tbc = m_tbc + 16'h0001;
            end
            if (start) m_run = 1'b1;
            m_tq = trig;
            m_pa = pa; m_pb = pb; m_pi = idx;
        end
    endtask

    task automatic advance();
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk("R1 edge count", {16'h0, pos[15:0]}, {16'h0, m_edge});
        chk("R4 revolutions", {16'h0, rev}, {16'h0, m_rev});
        chk("R6 position word", pos, {m_rev, m_edge});
        chk("R8 speed value", {16'h0, spd}, {16'h0, m_spd});
        chk("R3 direction", {31'h0, dir}, {31'h0, m_dir});
        chk("R7 timebase out", {31'h0, tbo}, {31'h0, m_tbo});
    endtask

    task automatic move(input int d);
        g = (g + d) & 3;
        {pa, pb} = gray_ab(g);
        advance();
    endtask

    task automatic pulse_index();
        idx = 1'b1; advance();
        idx = 1'b0; advance();
    endtask

    task automatic command(input logic c, input logic s);
        wr = 1'b1; ce = c; st = s; advance();
        wr = 1'b0; ce = 1'b0; st = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; pa = 0; pb = 0; idx = 0; qen = 1; sen = 0; per = 16'd3;
        wr = 0; ce = 0; st = 0;
        repeat (3) advance();
        rst = 1'b0;
        advance();
        // R11 reset state
        chk("R11 position after reset", pos, 32'h0);
        chk("R11 speed after reset", {16'h0, spd}, 32'h0);
        chk("R11 direction after reset", {31'h0, dir}, 32'h1);
        chk("R11 timebase after reset", {31'h0, tbo}, 32'h0);

        // R10 nothing moves before the start command
        repeat (3) move(1);
        chk("R10 frozen before start", pos, 32'h0);
        command(1'b1, 1'b0);
        repeat (2) move(1);
        chk("R10 clock-on alone does not start", pos, 32'h0);
        command(1'b1, 1'b1);

        // R1 / R3 counting in both directions
        repeat (4) move(1);
        chk("R1 four forward steps", {16'h0, pos[15:0]}, 32'd4);
        chk("R3 forward direction", {31'h0, dir}, 32'h1);
        repeat (2) move(-1);
        chk("R1 two reverse steps", {16'h0, pos[15:0]}, 32'd2);
        chk("R3 reverse direction", {31'h0, dir}, 32'h0);

        // R2 illegal double change
        move(2);
        chk("R2 illegal step not counted", {16'h0, pos[15:0]}, 32'd2);
        chk("R2 illegal step keeps direction", {31'h0, dir}, 32'h0);

        // R4 / R5 index handling
        move(1);
        idx = 1'b1; advance();
        chk("R4 forward index increments", {16'h0, rev}, 32'd1);
        chk("R5 index clears edge count", {16'h0, pos[15:0]}, 32'd0);
        idx = 1'b0; advance();
        move(-1);
        pulse_index();
        pulse_index();
        chk("R4 reverse index wraps", {16'h0, rev}, 32'h0000FFFF);
        chk("R6 position after wrap", pos, 32'hFFFF_0000);

        // R12 decoding disabled
        qen = 1'b0;
        repeat (3) move(1);
        pulse_index();
        chk("R12 counters hold while disabled", pos, 32'hFFFF_0000);
        qen = 1'b1;

        // R9 no capture without speed enable
        chk("R9 speed untouched while disabled", {16'h0, spd}, 32'h0);

        // R8 steady stepping every cycle, period 3 -> 8 edges per capture
        command(1'b1, 1'b1);
        sen = 1'b1;
        repeat (40) move(1);
        chk("R8 edges per time-base cycle", {16'h0, spd}, 32'd8);
        sen = 1'b0;
        repeat (20) move(1);
        chk("R9 speed holds after disable", {16'h0, spd}, 32'd8);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 16);
            idx = ($urandom % 40) == 0;
            if (($urandom % 500) == 0) per = 16'($urandom % 12);
            if (($urandom % 300) == 0) sen = ~sen;
            if (($urandom % 400) == 0) qen = ~qen;
            if (!qen && ($urandom % 50) == 0) qen = 1'b1;
            if (($urandom % 700) == 0) begin wr = 1; ce = 1; st = 1; end
            if (r < 6)       g = (g + 1) & 3;
            else if (r < 10) g = (g + 3) & 3;
            else if (r == 10) g = (g + 2) & 3;
            {pa, pb} = gray_ab(g);
            advance();
            wr = 0; ce = 0; st = 0;
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule